// File: doc/BRIEF.md
# Load-Use Interlock Controller

This block watches the two pipeline slots that follow decode in a five-stage in-order pipeline. The execute slot holds the younger instruction and the memory slot holds the older one. When the older instruction is a load whose result the younger instruction needs before the load data exists, the block raises a one-cycle freeze. During that cycle the fetch, decode and execute slots keep their contents. The memory and write-back slots keep moving, and an empty instruction enters the memory slot. That bubble makes the hazard condition false on the next cycle, so the freeze clears without further control.

The block also keeps a copy of the load data register and of the write-back instruction for one extra cycle, so a loaded value stays available to an instruction that waited through the freeze. A store that uses the loaded value only as its write data does not freeze. Instead, the block raises a select telling the memory write port to take the load data register.

Top module: `ilk_interlock`

## Requirements
- R1: While reset is high, and after reset until a non-empty instruction arrives, every slot reads kind code 0 (empty) and `stall` is low. Kind codes: 0 empty, 1 ALU, 2 load, 3 store, 4 jump, 5 branch.
- R2: `stall` is high when the memory slot holds a load (code 2), the execute slot holds an ALU instruction (code 1), and the load destination equals that instruction's operand A or operand B.
- R3: `stall` is high when the memory slot holds a load and the execute slot holds a load or store whose operand A (the address operand) equals the load destination.
- R4: A store in execute whose operand B alone matches the load destination causes no stall. On the next cycle, with that store in the memory slot and the load in write-back, `st_data_fwd` is high.
- R5: In a stall cycle the execute slot keeps its instruction and the decode inputs are ignored, while the memory slot's instruction moves to write-back and write-back's moves to the retired slot.
- R6: The cycle after a stall, the memory slot holds the empty instruction and `stall` is low, so exactly one cycle is lost.
- R7: `lmdr_q` takes `mem_rdata` at each clock where the memory slot holds a load. On every clock `lmdr1_q` takes `lmdr_q`, and the retired slot takes the write-back slot's kind and destination.
- R8: An empty, jump or branch instruction in execute never causes a stall, and neither does any instruction other than a load in the memory slot, whatever the register numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_kind | input | 3 | Kind code of the instruction leaving decode |
| dec_dest | input | RA_W | Destination register of the decoded instruction |
| dec_src_a | input | RA_W | Operand A register (address operand for memory ops) |
| dec_src_b | input | RA_W | Operand B register (store data for stores) |
| mem_rdata | input | DATA_W | Data read by the load in the memory slot |
| stall | output | 1 | Freeze fetch, decode and execute this cycle |
| ex_kind | output | 3 | Kind in the execute slot |
| ex_dest | output | RA_W | Destination in the execute slot |
| mem_kind | output | 3 | Kind in the memory slot |
| mem_dest | output | RA_W | Destination in the memory slot |
| wb_kind | output | 3 | Kind in the write-back slot |
| wb_dest | output | RA_W | Destination in the write-back slot |
| ret_kind | output | 3 | Kind in the retired copy slot |
| ret_dest | output | RA_W | Destination in the retired copy slot |
| lmdr_q | output | DATA_W | Load data register |
| lmdr1_q | output | DATA_W | One-cycle-delayed load data register |
| st_data_fwd | output | 1 | Memory write data should come from `lmdr_q` |

## Verification
The hardest situation to reach is a stall followed by the next cycle, where the held instruction, the bubble and the advancing load must all be in the right slots together. The inputs must therefore place a specific load directly ahead of a specific consumer. The bench does this for every pair of older and younger kinds and every pattern of operand match. It feeds the two instructions back to back after flushing the pipe, then presents an unrelated instruction during the decisive cycle to show that decode input is dropped while frozen. It follows the load for two more cycles to check both copies of the load data.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_ALU   = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_JUMP  = 3'd4,
    K_BRCH  = 3'd5
  } kind_e;

  function automatic logic is_mem(input kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction
endpackage

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  kind_e           ex_k,
  input  logic [RA_W-1:0] ex_a,
  input  logic [RA_W-1:0] ex_b,
  input  kind_e           mm_k,
  input  logic [RA_W-1:0] mm_d,
  input  logic [RA_W-1:0] mm_b,
  input  kind_e           wb_k,
  input  logic [RA_W-1:0] wb_d,
  output logic            stall,
  output logic            st_fwd
);
  logic ld_old, hit_a, hit_b, alu_use, addr_use;

  always_comb begin
    ld_old   = (mm_k == K_LOAD);
    hit_a    = (mm_d == ex_a);
    hit_b    = (mm_d == ex_b);
    alu_use  = (ex_k == K_ALU) && (hit_a || hit_b);
    addr_use = is_mem(ex_k) && hit_a;
    stall    = ld_old && (alu_use || addr_use);
    st_fwd   = (mm_k == K_STORE) && (wb_k == K_LOAD) && (wb_d == mm_b);
  end

  p_no_stall_nonload_r8: assert property (@(posedge clk) disable iff (rst)
    (mm_k != K_LOAD) |-> !stall);

  p_ctl_insn_never_waits_r8: assert property (@(posedge clk) disable iff (rst)
    (ex_k == K_JUMP || ex_k == K_BRCH || ex_k == K_NONE) |-> !stall);

  p_store_data_exempt_r4: assert property (@(posedge clk) disable iff (rst)
    (mm_k == K_LOAD && ex_k == K_STORE && mm_d == ex_b && mm_d != ex_a) |-> !stall);
endmodule

// File: rtl/ilk_stage_regs.sv
module ilk_stage_regs
  import ilk_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  kind_e           in_k,
  input  logic [RA_W-1:0] in_d,
  input  logic [RA_W-1:0] in_a,
  input  logic [RA_W-1:0] in_b,
  output kind_e           ex_k,
  output logic [RA_W-1:0] ex_d,
  output logic [RA_W-1:0] ex_a,
  output logic [RA_W-1:0] ex_b,
  output kind_e           mm_k,
  output logic [RA_W-1:0] mm_d,
  output logic [RA_W-1:0] mm_b,
  output kind_e           wb_k,
  output logic [RA_W-1:0] wb_d,
  output kind_e           rt_k,
  output logic [RA_W-1:0] rt_d
);
  // Execute slot: frozen while stalled, else loads decode output.
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_k <= K_NONE;
      ex_d <= '0;
      ex_a <= '0;
      ex_b <= '0;
    end else if (!stall) begin
      ex_k <= in_k;
      ex_d <= in_d;
      ex_a <= in_a;
      ex_b <= in_b;
    end
  end

  // Memory slot: takes a bubble on stall, else the execute instruction.
  always_ff @(posedge clk) begin
    if (rst || stall) begin
      mm_k <= K_NONE;
      mm_d <= '0;
      mm_b <= '0;
    end else begin
      mm_k <= ex_k;
      mm_d <= ex_d;
      mm_b <= ex_b;
    end
  end

  // Write-back and retired copy always advance.
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_k <= K_NONE;
      wb_d <= '0;
      rt_k <= K_NONE;
      rt_d <= '0;
    end else begin
      wb_k <= mm_k;
      wb_d <= mm_d;
      rt_k <= wb_k;
      rt_d <= wb_d;
    end
  end

  p_hold_ex_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(ex_k) && $stable(ex_d) && $stable(ex_a) && $stable(ex_b)));

  p_mem_advances_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (wb_k == $past(mm_k) && wb_d == $past(mm_d)));

  p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> (mm_k == K_NONE));

  p_retire_copy_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rt_k == $past(wb_k) && rt_d == $past(wb_d)));
endmodule

// File: rtl/ilk_load_regs.sv
module ilk_load_regs
  import ilk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  kind_e             mm_k,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] lmdr,
  output logic [DATA_W-1:0] lmdr1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lmdr  <= '0;
      lmdr1 <= '0;
    end else begin
      if (mm_k == K_LOAD) lmdr <= rdata;
      lmdr1 <= lmdr;
    end
  end

  p_lmdr_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (mm_k == K_LOAD) |=> (lmdr == $past(rdata)));

  p_lmdr1_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lmdr1 == $past(lmdr)));
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int RA_W   = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        dec_kind,
  input  logic [RA_W-1:0]   dec_dest,
  input  logic [RA_W-1:0]   dec_src_a,
  input  logic [RA_W-1:0]   dec_src_b,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              stall,
  output logic [2:0]        ex_kind,
  output logic [RA_W-1:0]   ex_dest,
  output logic [2:0]        mem_kind,
  output logic [RA_W-1:0]   mem_dest,
  output logic [2:0]        wb_kind,
  output logic [RA_W-1:0]   wb_dest,
  output logic [2:0]        ret_kind,
  output logic [RA_W-1:0]   ret_dest,
  output logic [DATA_W-1:0] lmdr_q,
  output logic [DATA_W-1:0] lmdr1_q,
  output logic              st_data_fwd
);
  kind_e           in_k, ex_k, mm_k, wb_k, rt_k;
  logic [RA_W-1:0] ex_a, ex_b, mm_b;

  assign in_k = kind_e'(dec_kind);

  ilk_stage_regs #(.RA_W(RA_W)) u_stages (
    .clk(clk), .rst(rst), .stall(stall),
    .in_k(in_k), .in_d(dec_dest), .in_a(dec_src_a), .in_b(dec_src_b),
    .ex_k(ex_k), .ex_d(ex_dest), .ex_a(ex_a), .ex_b(ex_b),
    .mm_k(mm_k), .mm_d(mem_dest), .mm_b(mm_b),
    .wb_k(wb_k), .wb_d(wb_dest),
    .rt_k(rt_k), .rt_d(ret_dest)
  );

  ilk_hazard #(.RA_W(RA_W)) u_hazard (
    .clk(clk), .rst(rst),
    .ex_k(ex_k), .ex_a(ex_a), .ex_b(ex_b),
    .mm_k(mm_k), .mm_d(mem_dest), .mm_b(mm_b),
    .wb_k(wb_k), .wb_d(wb_dest),
    .stall(stall), .st_fwd(st_data_fwd)
  );

  ilk_load_regs #(.DATA_W(DATA_W)) u_load (
    .clk(clk), .rst(rst), .mm_k(mm_k), .rdata(mem_rdata),
    .lmdr(lmdr_q), .lmdr1(lmdr1_q)
  );

  assign ex_kind  = ex_k;
  assign mem_kind = mm_k;
  assign wb_kind  = wb_k;
  assign ret_kind = rt_k;

  p_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (ex_kind == 3'd0 && mem_kind == 3'd0 && !stall));
endmodule

// File: tb/ilk_interlock_tb.sv
`timescale 1ns/1ps
module ilk_interlock_tb;
  localparam int RA_W   = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        dec_kind = 3'd0;
  logic [RA_W-1:0]   dec_dest = '0, dec_src_a = '0, dec_src_b = '0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              stall, st_data_fwd;
  logic [2:0]        ex_kind, mem_kind, wb_kind, ret_kind;
  logic [RA_W-1:0]   ex_dest, mem_dest, wb_dest, ret_dest;
  logic [DATA_W-1:0] lmdr_q, lmdr1_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ilk_interlock #(.RA_W(RA_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .dec_kind(dec_kind), .dec_dest(dec_dest),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .mem_rdata(mem_rdata),
    .stall(stall), .ex_kind(ex_kind), .ex_dest(ex_dest),
    .mem_kind(mem_kind), .mem_dest(mem_dest), .wb_kind(wb_kind),
    .wb_dest(wb_dest), .ret_kind(ret_kind), .ret_dest(ret_dest),
    .lmdr_q(lmdr_q), .lmdr1_q(lmdr1_q), .st_data_fwd(st_data_fwd)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input int k, input int d, input int a, input int b);
    dec_kind  = 3'(k);
    dec_dest  = RA_W'(d);
    dec_src_a = RA_W'(a);
    dec_src_b = RA_W'(b);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic exp_stall, exp_fwd;
    logic [DATA_W-1:0] val;
    int idx;
    idx = 0;
    repeat (3) step();
    check("R1 stall in reset", stall, 0);
    check("R1 ex empty in reset", ex_kind, 0);
    rst = 1'b0;
    step();
    check("R1 mem empty after reset", mem_kind, 0);
    check("R1 wb empty after reset", wb_kind, 0);
    check("R1 ret empty after reset", ret_kind, 0);
    check("R1 stall after reset", stall, 0);

    for (int ka = 0; ka < 6; ka++) begin
      for (int kb = 0; kb < 6; kb++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic ma, mb;
          ma = pat[0];
          mb = pat[1];
          idx++;
          val = 32'hA000_0000 + DATA_W'(idx);
          exp_stall = (ka == 2) && (((kb == 1) && (ma || mb)) ||
                                    ((kb == 2 || kb == 3) && ma));
          exp_fwd   = (ka == 2) && (kb == 3) && mb && !ma;
          // flush
          drive(0, 0, 0, 0);
          repeat (4) step();
          // older instruction A: dest 5
          drive(ka, 5, 1, 2);
          step();
          // younger B: dest 9, operands match 5 per pattern
          drive(kb, 9, ma ? 5 : 6, mb ? 5 : 7);
          step();
          check(exp_stall ? "R2/R3 stall expected" : "R8 no stall expected",
                stall, exp_stall);
          if (ka == 2 && kb == 3 && mb && !ma)
            check("R4 store data no stall", stall, 0);
          // unrelated C during decisive cycle; mem data for A
          drive(1, 12, 20, 21);
          mem_rdata = val;
          step();
          mem_rdata = ~val;
          check("R6 stall clears", stall, 0);
          check("R5 wb gets older", wb_dest, 5);
          check("R5 wb kind", wb_kind, ka);
          if (exp_stall) begin
            check("R5 ex held", ex_dest, 9);
            check("R5 ex kind held", ex_kind, kb);
            check("R6 bubble in mem", mem_kind, 0);
          end else begin
            check("R5 ex takes decode", ex_dest, 12);
            check("R5 mem takes B", mem_kind, kb);
          end
          check("R4 store fwd select", st_data_fwd, exp_fwd);
          if (ka == 2) check("R7 lmdr capture", lmdr_q, val);
          drive(0, 0, 0, 0);
          step();
          check("R7 ret dest copy", ret_dest, 5);
          check("R7 ret kind copy", ret_kind, ka);
          if (ka == 2) check("R7 lmdr1 copy", lmdr1_q, val);
          if (exp_stall) begin
            check("R5 B advances after stall", mem_kind, kb);
            check("R5 B dest after stall", mem_dest, 9);
          end else begin
            check("R5 C in mem", mem_dest, 12);
            check("R5 B in wb", wb_dest, 9);
          end
        end
      end
    end

    // reset in mid-flight
    drive(2, 5, 1, 2);
    step();
    drive(1, 9, 5, 5);
    step();
    check("R2 stall before reset", stall, 1);
    rst = 1'b1;
    step();
    check("R1 stall cleared by reset", stall, 0);
    check("R1 mem cleared by reset", mem_kind, 0);
    check("R1 ex cleared by reset", ex_kind, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule